// File: doc/BRIEF.md
# Multi-Mode Layer Pixel Blender

This block merges one overlay layer into a base video stream, one pixel per clock. Each accepted base pixel arrives with the overlay pixel and an in-band alpha for the same position. Start-of-frame and end-of-line markers come with the pixel. From these markers the block keeps the current output column and row. It then decides whether the overlay window covers that position. The window is placed by a horizontal and a vertical offset and sized by an overlay width and height.

A two-bit runtime mode selects how a covered pixel is formed. The layer can be hidden, drawn opaque, mixed with a programmed static alpha, or mixed with the alpha carried in the stream. A build-time capability parameter decides which alpha kinds exist in hardware. Every colour component is mixed with the same alpha. The result appears a fixed two cycles after the input handshake.

Top module: `layer_blend`

## Requirements
- R1: An input accepted in cycle n (in_valid high at the rising edge that ends cycle n) gives out_valid high in cycle n+2, and out_valid is high in no other cycle. After reset, out_valid and out_pix are 0.
- R2: With blend_mode = 0 (hidden), out_pix equals the base pixel at every position.
- R3: Column and row advance only on accepted pixels. A pixel with in_sof is at (0,0). After a pixel with in_eol, the column returns to 0 and the row increments; otherwise the column increments. A position is covered when hoff_eff <= x < hoff_eff + ovl_w and v_off <= y < v_off + ovl_h. Outside the window, out_pix equals the base pixel in every mode.
- R4: With blend_mode = 1 (opaque), a covered pixel is output as the overlay pixel.
- R5: With blend_mode = 2, each CW-bit component of a covered pixel is (a*o + (M-a)*b + (M-1)/2) / M, using integer division. Here a is static_alpha, M = 2^CW-1, o is the overlay component and b is the base component.
- R6: With blend_mode = 3, the same formula applies with a equal to ovl_alpha of that pixel.
- R7: The parameter CAPS sets which alpha modes exist: 0 = none, 1 = static only, 2 = in-stream only, 3 = both. Selecting mode 2 or 3 when the hardware lacks it makes covered pixels opaque.
- R8: The horizontal offset is used rounded down to a multiple of HSTEP (hoff_eff = floor(h_off/HSTEP)*HSTEP). Its low remainder is ignored.
- R9: While out_valid is low, out_pix holds its last value.
- R10: Cycles with in_valid low do not advance the coordinates and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of its line |
| base_pix | input | NCOMP*CW | Base layer pixel |
| ovl_pix | input | NCOMP*CW | Overlay pixel at the same position |
| ovl_alpha | input | CW | In-stream alpha of the overlay pixel |
| blend_mode | input | 2 | 0 hidden, 1 opaque, 2 static alpha, 3 in-stream alpha |
| static_alpha | input | CW | Alpha used in mode 2 |
| h_off | input | 16 | Overlay left edge column |
| v_off | input | 16 | Overlay top edge row |
| ovl_w | input | 16 | Overlay width in pixels |
| ovl_h | input | 16 | Overlay height in lines |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | NCOMP*CW | Blended pixel |

## Verification
Each result is due exactly two cycles after its input handshake. The driver records, for each pushed expectation, the cycle in which the output must show. The monitor compares that due cycle with the cycle in which out_valid actually appears, as well as the pixel value. The hold of out_pix during idle cycles and the empty scoreboard after draining are both checked once the pipeline's two stages have flushed. A second instance with static alpha only is compared against the same stimulus so that the capability fallback is observed at the ports.

// File: rtl/layer_blend.sv
module layer_blend #(
  parameter int CW    = 8,
  parameter int NCOMP = 3,
  parameter int CAPS  = 3,
  parameter int HSTEP = 4,
  localparam int PW   = CW * NCOMP,
  localparam int NW   = 2 * CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic [PW-1:0] base_pix,
  input  logic [PW-1:0] ovl_pix,
  input  logic [CW-1:0] ovl_alpha,
  input  logic [1:0]    blend_mode,
  input  logic [CW-1:0] static_alpha,
  input  logic [15:0]   h_off,
  input  logic [15:0]   v_off,
  input  logic [15:0]   ovl_w,
  input  logic [15:0]   ovl_h,
  output logic          out_valid,
  output logic [PW-1:0] out_pix
);

  localparam bit HAS_STATIC = (CAPS == 1) || (CAPS == 3);
  localparam bit HAS_PIXEL  = (CAPS >= 2);
  localparam logic [CW-1:0] AMAX = '1;

  logic [15:0] x_q, y_q;
  logic [15:0] cur_x, cur_y, hoff_eff;
  logic        covered;
  logic [CW-1:0] alpha;

  assign cur_x    = in_sof ? 16'd0 : x_q;
  assign cur_y    = in_sof ? 16'd0 : y_q;
  assign hoff_eff = 16'((32'(h_off) / HSTEP) * HSTEP);
  assign covered  = ({1'b0, cur_x} >= {1'b0, hoff_eff}) &&
                    ({1'b0, cur_x} <  {1'b0, hoff_eff} + {1'b0, ovl_w}) &&
                    ({1'b0, cur_y} >= {1'b0, v_off}) &&
                    ({1'b0, cur_y} <  {1'b0, v_off} + {1'b0, ovl_h});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (in_valid) begin
      if (in_eol) begin
        x_q <= '0;
        y_q <= cur_y + 16'd1;
      end else begin
        x_q <= cur_x + 16'd1;
        y_q <= cur_y;
      end
    end
  end

  always_comb begin
    case (blend_mode)
      2'd0:    alpha = '0;
      2'd1:    alpha = AMAX;
      2'd2:    alpha = HAS_STATIC ? static_alpha : AMAX;
      default: alpha = HAS_PIXEL ? ovl_alpha : AMAX;
    endcase
    if (!covered) alpha = '0;
  end

  logic          s1_v;
  logic [CW-1:0] s1_a;
  logic [PW-1:0] s1_b, s1_o, mix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_a <= '0;
      s1_b <= '0;
      s1_o <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_a <= alpha;
        s1_b <= base_pix;
        s1_o <= ovl_pix;
      end
    end
  end

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [NW-1:0] num;
    assign num = NW'(s1_a) * NW'(s1_o[c*CW +: CW]) +
                 NW'(AMAX - s1_a) * NW'(s1_b[c*CW +: CW]) +
                 NW'(AMAX >> 1);
    assign mix[c*CW +: CW] = CW'(num / NW'(AMAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) out_pix <= mix;
    end
  end

endmodule

// File: rtl/layer_blend_chk.sv
module layer_blend_chk #(
  parameter int CW    = 8,
  parameter int NCOMP = 3,
  parameter int CAPS  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [CW*NCOMP-1:0] base_pix,
  input logic [CW-1:0]       ovl_alpha,
  input logic [1:0]          blend_mode,
  input logic [CW-1:0]       static_alpha,
  input logic                out_valid,
  input logic [CW*NCOMP-1:0] out_pix
);

  // R1
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R1
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // R2
  hidden_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && blend_mode == 2'd0) |=> ##1 (out_pix == $past(base_pix, 2)));

  // R5
  static_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((CAPS == 1 || CAPS == 3) && in_valid && blend_mode == 2'd2 && static_alpha == '0)
      |=> ##1 (out_pix == $past(base_pix, 2)));

  // R6
  pixel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CAPS >= 2 && in_valid && blend_mode == 2'd3 && ovl_alpha == '0)
      |=> ##1 (out_pix == $past(base_pix, 2)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_pix));

endmodule

bind layer_blend layer_blend_chk #(.CW(CW), .NCOMP(NCOMP), .CAPS(CAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_pix(base_pix),
  .ovl_alpha(ovl_alpha), .blend_mode(blend_mode), .static_alpha(static_alpha),
  .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/sim_layer_blend.sv
module sim_layer_blend;
  localparam int CW = 8, NC = 3, PW = 24, HS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_sof, in_eol;
  logic [PW-1:0] base_pix, ovl_pix;
  logic [CW-1:0] ovl_alpha, static_alpha;
  logic [1:0] blend_mode;
  logic [15:0] h_off, v_off, ovl_w, ovl_h;
  logic ov0, ov1;
  logic [PW-1:0] op0, op1;

  layer_blend #(.CW(CW), .NCOMP(NC), .CAPS(3), .HSTEP(HS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .base_pix(base_pix), .ovl_pix(ovl_pix), .ovl_alpha(ovl_alpha),
    .blend_mode(blend_mode), .static_alpha(static_alpha), .h_off(h_off), .v_off(v_off),
    .ovl_w(ovl_w), .ovl_h(ovl_h), .out_valid(ov0), .out_pix(op0));

  layer_blend #(.CW(CW), .NCOMP(NC), .CAPS(1), .HSTEP(HS)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .base_pix(base_pix), .ovl_pix(ovl_pix), .ovl_alpha(ovl_alpha),
    .blend_mode(blend_mode), .static_alpha(static_alpha), .h_off(h_off), .v_off(v_off),
    .ovl_w(ovl_w), .ovl_h(ovl_h), .out_valid(ov1), .out_pix(op1));

  int vec = 0, bad = 0, cyc = 0, bx = 0, by = 0;
  logic [PW-1:0] q0[$], q1[$];
  int d0[$], d1[$];
  string t0[$], t1[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PW-1:0] model(int caps, logic [PW-1:0] b, logic [PW-1:0] o,
                                          logic [CW-1:0] pa, int x, int y);
    logic [PW-1:0] r;
    int ho, a;
    bit cov;
    ho = (int'(h_off) / HS) * HS;
    cov = x >= ho && x < ho + int'(ovl_w) && y >= int'(v_off) && y < int'(v_off) + int'(ovl_h);
    case (blend_mode)
      2'd0: a = 0;
      2'd1: a = 255;
      2'd2: a = (caps == 1 || caps == 3) ? int'(static_alpha) : 255;
      default: a = (caps >= 2) ? int'(pa) : 255;
    endcase
    if (!cov) a = 0;
    for (int c = 0; c < NC; c++)
      r[c*CW +: CW] = CW'((a * int'(o[c*CW +: CW]) + (255 - a) * int'(b[c*CW +: CW]) + 127) / 255);
    return r;
  endfunction

  task automatic send(logic [PW-1:0] b, logic [PW-1:0] o, logic [CW-1:0] pa,
                      bit sof, bit eol, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_eol = eol;
    base_pix = b; ovl_pix = o; ovl_alpha = pa;
    if (sof) begin bx = 0; by = 0; end
    q0.push_back(model(3, b, o, pa, bx, by)); d0.push_back(cyc + 2); t0.push_back(tag);
    q1.push_back(model(1, b, o, pa, bx, by)); d1.push_back(cyc + 2);
    t1.push_back(blend_mode == 2'd3 ? "R7" : tag);
    if (eol) begin bx = 0; by++; end else bx++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    end
  endtask

  task automatic frame(string tag, bit gap);
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 8; x++) begin
        send({8'(x*20 + y*7), 8'(255 - x*9), 8'(y*50 + 3)},
             {8'(x*31 + 5), 8'(y*60), 8'(200 - x*11)},
             8'(x*37 + y*11), x == 0 && y == 0, x == 7, tag);
        if (gap) idle(1);
      end
    idle(4);
  endtask

  task automatic chk(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (ov0) begin
      if (q0.size() == 0) chk(1'b0, "R1", op0, '0);
      else begin
        logic [PW-1:0] e; int d; string t;
        e = q0.pop_front(); d = d0.pop_front(); t = t0.pop_front();
        chk(op0 == e && cyc == d, t, op0, e);
        if (cyc != d) $display("  R1 latency: at cycle %0d, due %0d", cyc, d);
      end
    end
    if (ov1) begin
      if (q1.size() == 0) chk(1'b0, "R1", op1, '0);
      else begin
        logic [PW-1:0] e; int d; string t;
        e = q1.pop_front(); d = d1.pop_front(); t = t1.pop_front();
        chk(op1 == e && cyc == d, t, op1, e);
        if (cyc != d) $display("  R1 latency: at cycle %0d, due %0d", cyc, d);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [PW-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    base_pix = '0; ovl_pix = '0; ovl_alpha = '0; blend_mode = 2'd0;
    static_alpha = 8'h80; h_off = 16'd4; v_off = 16'd1; ovl_w = 16'd3; ovl_h = 16'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ov0 && op0 == '0, "R1", op0, '0);

    blend_mode = 2'd0; frame("R2", 1'b0);
    blend_mode = 2'd1; frame("R4", 1'b0);
    blend_mode = 2'd2; frame("R5", 1'b0);
    blend_mode = 2'd3; frame("R6", 1'b0);
    blend_mode = 2'd1; h_off = 16'd5; frame("R8", 1'b0);
    blend_mode = 2'd2; h_off = 16'd4; ovl_w = 16'd4; v_off = 16'd2; ovl_h = 16'd2;
    static_alpha = 8'h40; frame("R3", 1'b0);
    static_alpha = 8'hFF; frame("R5", 1'b0);
    static_alpha = 8'h00; frame("R5", 1'b0);
    blend_mode = 2'd3; frame("R10", 1'b1);
    send(24'h102030, 24'hA0B0C0, 8'h55, 1'b1, 1'b0, "R3");
    send(24'h112233, 24'hA1B1C1, 8'h66, 1'b0, 1'b0, "R3");
    send(24'h445566, 24'hA2B2C2, 8'h77, 1'b0, 1'b0, "R3");
    idle(2);
    frame("R3", 1'b0);

    held = op0;
    idle(5);
    chk(op0 == held, "R9", op0, held);
    chk(q0.size() == 0 && q1.size() == 0, "R10", PW'(q0.size()), '0);
    summary();
  end
endmodule